// File: doc/BRIEF.md
# In-Service Priority Clear Guard

This block keeps the in-service state of an interrupt controller. It holds a 16-bit in-service register with one bit per priority level, where bit 0 is the most urgent level. It also keeps three sticky flags. Each flag records that an interrupt of one class is being handled. The classes are the high-level non-maskable class, the high-level maskable class and the normal-level maskable class.

A hardware side port updates this state. An acknowledge sets the bit for one level and the flag for its class. An end-of-service strobe retires the most urgent bit that is set.

Software reaches the block through a plain register bus. It cannot overwrite the in-service state freely. To wipe the state, it first writes all ones to a separate key register. It then writes zero to the in-service register. That second write clears the bits and the flags, and it locks the key again.

The bus has no back-pressure. An access is taken in the cycle its request is high, and read data is returned in that same cycle.

Top module: `isprio_guard`

## Requirements
- R1: After reset, from power-up or asserted at any later time, the in-service bits, the class flags and the key all read 0x0000.
- R2: An access with `bus_full` low does not change the key, the in-service bits or the flags.
- R3: A full-width write of 0xFFFF to the key (address 1) arms it. While armed, the key reads 0xFFFF.
- R4: A full-width key write of any value other than 0xFFFF or 0x0000 leaves the key unchanged.
- R5: A full-width key write of 0x0000 disarms the key and leaves the in-service bits unchanged.
- R6: A full-width write of 0x0000 to the in-service register (address 0) while the key is armed has three effects one cycle later: the in-service bits are zero, all three flags are zero, and the key reads 0x0000.
- R7: A write to the in-service register that does not meet R6 has no effect on the in-service bits, the flags or the key. This covers a locked key, a nonzero value and a narrow access.
- R8: An acknowledge sets in-service bit `ack_level`. It also sets the flag selected by `ack_class`: 0 is the high-level non-maskable class, 1 the high-level maskable class, 2 the normal-level maskable class, and 3 sets no flag.
- R9: End of service clears the lowest-index set bit. When it falls in the same cycle as an acknowledge, the clear applies to the old state and then the acknowledged bit is set. End of service with no bit set does nothing.
- R10: If an armed clear (R6) and a hardware acknowledge or end of service fall in the same cycle, the armed clear wins and the result is all zero.
- R11: A read of address 2 returns the flags in bits [2:0] and zero above them. Writes to address 2 are ignored. A read of address 3 returns zero.
- R12: The key only ever holds 0x0000 or 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 in-service, 1 key, 2 flags |
| bus_full | input | 1 | Access is full 16-bit width |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, same cycle, zero when not reading |
| ack_valid | input | 1 | Hardware acknowledge strobe |
| ack_level | input | 4 | Priority level being acknowledged |
| ack_class | input | 2 | Class of the acknowledged interrupt |
| eos_valid | input | 1 | End-of-service strobe |
| isr_out | output | 16 | In-service bits |
| flags_out | output | 3 | Class in-progress flags |

## Verification
A software armed clear and a hardware update can land on the same clock edge. The bench provokes this by arming the key and then driving the zero write together with an acknowledge in one cycle. It judges the result by reading back zero bits, zero flags and a relocked key. The bench also drives an acknowledge together with an end of service. It checks that the most urgent old bit is retired while the new level still appears.

// File: rtl/isprio_pkg.sv
package isprio_pkg;
  typedef enum logic [1:0] {
    A_ISR  = 2'd0,
    A_KEY  = 2'd1,
    A_FLG  = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/isprio_decode.sv
module isprio_decode
  import isprio_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         req,
  input  logic         we,
  input  logic [1:0]   addr,
  input  logic         full,
  input  logic [W-1:0] wdata,
  output logic         key_arm,
  output logic         key_disarm,
  output logic         isr_zero_wr
);
  logic wr_full;
  assign wr_full     = req && we && full;
  assign key_arm     = wr_full && (addr == A_KEY) && (wdata == '1);
  assign key_disarm  = wr_full && (addr == A_KEY) && (wdata == '0);
  assign isr_zero_wr = wr_full && (addr == A_ISR) && (wdata == '0);
endmodule

// File: rtl/isprio_key.sv
module isprio_key #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm,
  input  logic         disarm,
  input  logic         relock,
  output logic [W-1:0] key_q,
  output logic         armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              key_q <= '0;
    else if (relock||disarm) key_q <= '0;
    else if (arm)            key_q <= '1;
  end
  assign armed = (key_q == '1);
endmodule

// File: rtl/isprio_core.sv
module isprio_core #(
  parameter int W    = 16,
  parameter int NCLS = 3,
  localparam int LW  = $clog2(W),
  localparam int CW  = $clog2(NCLS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ack_valid,
  input  logic [LW-1:0] ack_level,
  input  logic [CW-1:0] ack_class,
  input  logic          eos_valid,
  output logic [W-1:0]  isr_q,
  output logic [NCLS-1:0] flg_q
);
  logic [W-1:0] lowest, after_eos, set_mask, isr_d;

  assign lowest    = isr_q & (~isr_q + W'(1));
  assign after_eos = eos_valid ? (isr_q & ~lowest) : isr_q;
  assign set_mask  = ack_valid ? (W'(1) << ack_level) : '0;
  assign isr_d     = clr ? '0 : (after_eos | set_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= isr_d;
  end

  for (genvar c = 0; c < NCLS; c++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   flg_q[c] <= 1'b0;
      else if (clr)                                 flg_q[c] <= 1'b0;
      else if (ack_valid && ack_class == CW'(c))    flg_q[c] <= 1'b1;
    end
  end
endmodule

// File: rtl/isprio_guard.sv
module isprio_guard
  import isprio_pkg::*;
#(
  parameter int W    = 16,
  parameter int NCLS = 3,
  localparam int LW  = $clog2(W),
  localparam int CW  = $clog2(NCLS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic          bus_full,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic          ack_valid,
  input  logic [LW-1:0] ack_level,
  input  logic [CW-1:0] ack_class,
  input  logic          eos_valid,
  output logic [W-1:0]  isr_out,
  output logic [NCLS-1:0] flags_out
);
  logic         key_arm, key_disarm, isr_zero_wr, armed, clr;
  logic [W-1:0] key_q;

  isprio_decode #(.W(W)) u_dec (
    .req(bus_req), .we(bus_we), .addr(bus_addr), .full(bus_full),
    .wdata(bus_wdata), .key_arm(key_arm), .key_disarm(key_disarm),
    .isr_zero_wr(isr_zero_wr)
  );

  assign clr = isr_zero_wr && armed;

  isprio_key #(.W(W)) u_key (
    .clk(clk), .rst_n(rst_n), .arm(key_arm), .disarm(key_disarm),
    .relock(clr), .key_q(key_q), .armed(armed)
  );

  isprio_core #(.W(W), .NCLS(NCLS)) u_core (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ack_valid(ack_valid),
    .ack_level(ack_level), .ack_class(ack_class), .eos_valid(eos_valid),
    .isr_q(isr_out), .flg_q(flags_out)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_req && !bus_we) begin
      case (bus_addr)
        A_ISR:   bus_rdata = isr_out;
        A_KEY:   bus_rdata = key_q;
        A_FLG:   bus_rdata = W'(flags_out);
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/isprio_guard_chk.sv
module isprio_guard_chk #(
  parameter int W    = 16,
  parameter int NCLS = 3,
  localparam int LW  = $clog2(W),
  localparam int CW  = $clog2(NCLS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_we,
  input logic [1:0]    bus_addr,
  input logic          bus_full,
  input logic [W-1:0]  bus_wdata,
  input logic          ack_valid,
  input logic [LW-1:0] ack_level,
  input logic          eos_valid,
  input logic [W-1:0]  isr_out,
  input logic [NCLS-1:0] flags_out,
  input logic [W-1:0]  key_q
);
  logic armed_clear, quiet_hw;
  assign armed_clear = bus_req && bus_we && bus_full && bus_addr == 2'd0 &&
                       bus_wdata == '0 && key_q == '1;
  assign quiet_hw    = !ack_valid && !eos_valid;

  AST_KEY_TWO_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
    key_q == '0 || key_q == '1);  // R12
  AST_ARMED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    armed_clear |=> isr_out == '0 && flags_out == '0 && key_q == '0);  // R6
  AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_addr == 2'd0 && key_q == '0 && quiet_hw
    |=> $stable(isr_out) && $stable(flags_out));  // R7
  AST_NARROW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_full |=> $stable(key_q));  // R2
  AST_DISARM_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_full && bus_addr == 2'd1 && bus_wdata == '0 && quiet_hw
    |=> $stable(isr_out) && key_q == '0);  // R5
  AST_ACK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && !armed_clear |=> isr_out[$past(ack_level)]);  // R8
endmodule

bind isprio_guard isprio_guard_chk #(.W(W), .NCLS(NCLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_full(bus_full), .bus_wdata(bus_wdata),
  .ack_valid(ack_valid), .ack_level(ack_level), .eos_valid(eos_valid),
  .isr_out(isr_out), .flags_out(flags_out), .key_q(key_q)
);

// File: tb/isprio_guard_bench.sv
`timescale 1ns/1ps
module isprio_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 0, bus_we = 0, bus_full = 0;
  logic [1:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic        ack_valid = 0, eos_valid = 0;
  logic [3:0]  ack_level = 0;
  logic [1:0]  ack_class = 0;
  logic [15:0] isr_out;
  logic [2:0]  flags_out;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  isprio_guard u_isprio_guard (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_full(bus_full), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ack_valid(ack_valid), .ack_level(ack_level),
    .ack_class(ack_class), .eos_valid(eos_valid), .isr_out(isr_out),
    .flags_out(flags_out)
  );

  // fields: kind(0 bus wr,1 ack,2 eos) addr full wdata lvl cls | exp isr, key, flags
  localparam logic [61:0] VEC [0:16] = '{
    {2'd1,2'd0,1'b0,16'h0000,4'd3,2'd0, 16'h0008,16'h0000,3'b001}, // R8
    {2'd1,2'd0,1'b0,16'h0000,4'd7,2'd2, 16'h0088,16'h0000,3'b101}, // R8
    {2'd0,2'd1,1'b1,16'h1234,4'd0,2'd0, 16'h0088,16'h0000,3'b101}, // R4
    {2'd0,2'd0,1'b1,16'h0000,4'd0,2'd0, 16'h0088,16'h0000,3'b101}, // R7
    {2'd0,2'd1,1'b0,16'hFFFF,4'd0,2'd0, 16'h0088,16'h0000,3'b101}, // R2
    {2'd0,2'd1,1'b1,16'hFFFF,4'd0,2'd0, 16'h0088,16'hFFFF,3'b101}, // R3
    {2'd0,2'd0,1'b1,16'h00FF,4'd0,2'd0, 16'h0088,16'hFFFF,3'b101}, // R7
    {2'd0,2'd0,1'b0,16'h0000,4'd0,2'd0, 16'h0088,16'hFFFF,3'b101}, // R2
    {2'd0,2'd1,1'b1,16'h0000,4'd0,2'd0, 16'h0088,16'h0000,3'b101}, // R5
    {2'd0,2'd1,1'b1,16'hFFFF,4'd0,2'd0, 16'h0088,16'hFFFF,3'b101}, // R3
    {2'd0,2'd0,1'b1,16'h0000,4'd0,2'd0, 16'h0000,16'h0000,3'b000}, // R6
    {2'd1,2'd0,1'b0,16'h0000,4'd15,2'd1,16'h8000,16'h0000,3'b010}, // R8
    {2'd1,2'd0,1'b0,16'h0000,4'd2,2'd3, 16'h8004,16'h0000,3'b010}, // R8
    {2'd2,2'd0,1'b0,16'h0000,4'd0,2'd0, 16'h8000,16'h0000,3'b010}, // R9
    {2'd0,2'd2,1'b1,16'h0000,4'd0,2'd0, 16'h8000,16'h0000,3'b010}, // R11
    {2'd2,2'd0,1'b0,16'h0000,4'd0,2'd0, 16'h0000,16'h0000,3'b010}, // R9
    {2'd2,2'd0,1'b0,16'h0000,4'd0,2'd0, 16'h0000,16'h0000,3'b010}  // R9
  };

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic quiet();
    bus_req = 0; bus_we = 0; bus_full = 0; bus_addr = 0; bus_wdata = 0;
    ack_valid = 0; eos_valid = 0; ack_level = 0; ack_class = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    bus_req = 1; bus_we = 0; bus_full = 1; bus_addr = a;
    #0.5 d = bus_rdata;
    bus_req = 0;
  endtask

  task automatic wr(logic [1:0] a, logic f, logic [15:0] d);
    @(negedge clk); quiet();
    bus_req = 1; bus_we = 1; bus_addr = a; bus_full = f; bus_wdata = d;
    @(negedge clk); quiet();
  endtask

  task automatic hw(logic a, logic [3:0] l, logic [1:0] c, logic e);
    @(negedge clk); quiet();
    ack_valid = a; ack_level = l; ack_class = c; eos_valid = e;
    @(negedge clk); quiet();
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 isr", isr_out, 16'h0);
    chk("R1 flags", {13'h0, flags_out}, 16'h0);
    rd(2'd1, d); chk("R1 key", d, 16'h0);

    for (int i = 0; i < 17; i++) begin
      logic [61:0] v;
      v = VEC[i];
      @(negedge clk); quiet();
      case (v[61:60])
        2'd0: begin bus_req = 1; bus_we = 1; bus_addr = v[59:58];
                    bus_full = v[57]; bus_wdata = v[56:41]; end
        2'd1: begin ack_valid = 1; ack_level = v[40:37]; ack_class = v[36:35]; end
        default: eos_valid = 1;
      endcase
      @(negedge clk); quiet();
      chk($sformatf("vec%0d isr R6-R9", i), isr_out, v[34:19]);
      chk($sformatf("vec%0d flags R8", i), {13'h0, flags_out}, {13'h0, v[2:0]});
      rd(2'd1, d);
      chk($sformatf("vec%0d key R12", i), d, v[18:3]);
    end

    rd(2'd2, d); chk("R11 flag read", d, 16'h0002);
    rd(2'd3, d); chk("R11 unused addr", d, 16'h0000);
    rd(2'd0, d); chk("R11 isr read", d, 16'h0000);

    hw(1, 4'd0, 2'd2, 0);
    hw(1, 4'd5, 2'd2, 0);
    chk("R9 setup", isr_out, 16'h0021);
    hw(1, 4'd1, 2'd0, 1);
    chk("R9 ack with eos", isr_out, 16'h0022);
    chk("R8 flags", {13'h0, flags_out}, 16'h0007);

    wr(2'd1, 1, 16'hFFFF);
    @(negedge clk); quiet();
    bus_req = 1; bus_we = 1; bus_full = 1; bus_addr = 2'd0; bus_wdata = 16'h0;
    ack_valid = 1; ack_level = 4'd9; ack_class = 2'd0; eos_valid = 1;
    @(negedge clk); quiet();
    chk("R10 isr", isr_out, 16'h0);
    chk("R10 flags", {13'h0, flags_out}, 16'h0);
    rd(2'd1, d); chk("R10 key", d, 16'h0);

    wr(2'd1, 1, 16'hFFFF);
    hw(1, 4'd4, 2'd1, 0);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 isr after reset", isr_out, 16'h0);
    chk("R1 flags after reset", {13'h0, flags_out}, 16'h0);
    rd(2'd1, d); chk("R1 key after reset", d, 16'h0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule